// File: doc/BRIEF.md
# Banked Data Memory Access Unit

This unit serves the fetch and store operations of an 8-bit stack processor against up to four small data memories. The two low bits of the current opcode name a bank. The low bits of the top-of-stack byte give the address inside that bank. A store writes the next-on-stack byte into the selected bank, and a fetch returns the byte held at that address. Each bank is configured as writable storage or as a fixed table.

To save storage, the logical banks share two physical arrays. The first array is split by a major address offset, so each bank it holds owns one contiguous slice of the array. The second array is wider, and each bank it holds owns one lane of every row. Each array is built either with a combinational read or with a read that is registered on the clock. A parameter picks the read style for each array. A bank that is left unconfigured reads back as zero.

Top module: `dmem_access_unit`

## Requirements
- R1: `op_bank` (opcode bits [1:0]) selects the bank that is read and written. With the default parameters:
  - bank 0 is writable and sits in the offset array at slot 0;
  - bank 1 is a fixed table and sits in the offset array at slot 1;
  - bank 2 is writable and sits in the lane array at lane 1;
  - bank 3 is writable and sits in the lane array at lane 0.
- R2: Only `tos[3:0]` addresses a bank under the defaults (parameters `A_AW` and `B_AW`). Bits [7:4] of `tos` do not affect which word is read or written.
- R3: A store takes effect only in a cycle where `wr_cmd` is 1 and the selected bank is writable. With `wr_cmd` at 0, no memory content changes.
- R4: A fixed-table bank is never written. Under the defaults, offset-array word w (0..31) holds (w*37+5) mod 256 from time zero, and bank 1 address a reads word 16+a.
- R5: The stored value is `nos`. In the lane array, each 9-bit word is zero-extended, so bit 8 of every stored word is 0.
- R6: In the offset array, the physical word is {slot, tos[3:0]}. A store to bank 0 never changes any word that bank 1 reads.
- R7: In the lane array, the physical word is {tos[3:0], lane}. A store to one lane never changes the other lane of the same row.
- R8: Read timing differs by array:
  - The offset array (combinational by default) shows the word at the current address. A store made at a clock edge is visible in the cycle after that edge.
  - The lane array (registered by default) returns the row addressed in the previous cycle, as it stood before any store made at that same edge. The lane shown is the one belonging to the bank selected now.
- R9: A bank whose bit in `BANK_EN` is 0 reads as 0x00 whatever the memory holds.
- R10: While `rst_n` is 0, the registered read row is cleared, so a lane-array bank reads 0x00. The lane array holds zeros from time zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_bank | input | 2 | Bank number taken from opcode bits [1:0] |
| wr_cmd | input | 1 | Store command for this cycle |
| tos | input | 8 | Top-of-stack byte; its low bits are the address |
| nos | input | 8 | Next-on-stack byte; the store data |
| rd_data | output | 8 | Fetched byte |

## Verification
A result from the offset array is due in the same cycle as its bank and address, and a store there is visible one edge later. A result from the lane array is due one edge after its address, with the lane chosen by the bank of the current cycle, and it never includes a store made at that same edge. The bench drives its inputs just after the falling edge and compares 1 ns later, against a behavioural model whose arrays and captured row advance only on the rising edge. In this way, every one of these delays is counted exactly once. A second instance, with bank 3 disabled, receives the same stimulus and must read zero for that bank.

// File: rtl/dmem_pkg.sv
// Shared constants and helpers for the banked data memory access unit.
// Assumes an 8-bit data path and at most four banks.
package dmem_pkg;
    localparam int DATA_W  = 8;
    localparam int N_BANKS = 4;
    localparam int SLOT_W  = 2;

    typedef logic [1:0]        bank_t;
    typedef logic [DATA_W-1:0] byte_t;

    // Byte value of the optional initial image for a physical word.
    function automatic byte_t image_byte(input int w, input byte_t mul, input byte_t add);
        int v;
        v = w * int'(mul) + int'(add);
        return byte_t'(v);
    endfunction
endpackage

// File: rtl/dmem_bank_decode.sv
// Bank decoder: turns the opcode bank number and the store command into
// per-array hit and write-enable signals, plus the slot/lane field of the bank.
// Assumes the bank configuration is fixed at elaboration.
module dmem_bank_decode
    import dmem_pkg::*;
#(
    parameter logic [N_BANKS-1:0]        BANK_EN   = 4'b1111,
    parameter logic [N_BANKS-1:0]        BANK_RAM  = 4'b1101,
    parameter logic [N_BANKS-1:0]        BANK_IN_B = 4'b1100,
    parameter logic [N_BANKS*SLOT_W-1:0] BANK_SLOT = 8'b00_01_01_00
) (
    input  bank_t             bank,
    input  logic              wr_cmd,
    output logic              hit_a,
    output logic              hit_b,
    output logic              we_a,
    output logic              we_b,
    output logic [SLOT_W-1:0] slot
);
    logic [N_BANKS-1:0]    in_a_vec;
    logic [N_BANKS-1:0]    in_b_vec;
    logic [N_BANKS-1:0]    ram_vec;
    logic [SLOT_W-1:0]     slot_tab [N_BANKS];

    // Per-bank table of array membership, writability and slot.
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign in_a_vec[b] = BANK_EN[b] & ~BANK_IN_B[b];
        assign in_b_vec[b] = BANK_EN[b] &  BANK_IN_B[b];
        assign ram_vec[b]  = BANK_EN[b] &  BANK_RAM[b];
        assign slot_tab[b] = BANK_SLOT[b*SLOT_W +: SLOT_W];
    end

    // Select the table row of the current bank and gate the store.
    always_comb begin
        hit_a = in_a_vec[bank];
        hit_b = in_b_vec[bank];
        slot  = slot_tab[bank];
        we_a  = wr_cmd & hit_a & ram_vec[bank];
        we_b  = wr_cmd & hit_b & ram_vec[bank];
    end
endmodule

// File: rtl/dmem_offset_array.sv
// Offset-packed physical array: byte-wide words, where each logical bank owns
// the slice selected by a major offset (sel) placed above the address bits.
// Read is combinational or registered according to SYNC.
// Assumes the write port and the read port share the same address.
module dmem_offset_array
    import dmem_pkg::*;
#(
    parameter int    AW       = 4,
    parameter int    SEL_W    = 1,
    parameter bit    SYNC     = 1'b0,
    parameter bit    INIT_EN  = 1'b1,
    parameter byte_t INIT_MUL = 8'd37,
    parameter byte_t INIT_ADD = 8'd5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [AW-1:0]    addr,
    input  byte_t            wdata,
    output byte_t            rdata
);
    localparam int PA_W  = AW + SEL_W;
    localparam int DEPTH = 1 << PA_W;

    typedef byte_t img_t [DEPTH];

    // Build the start-up contents: the computed image, or all zeros.
    function automatic img_t build_image();
        img_t m;
        for (int w = 0; w < DEPTH; w++) begin
            m[w] = INIT_EN ? image_byte(w, INIT_MUL, INIT_ADD) : '0;
        end
        return m;
    endfunction

    byte_t            mem [DEPTH] = build_image();
    logic [PA_W-1:0]  paddr;

    assign paddr = {sel, addr};

    // Store port.
    always_ff @(posedge clk) begin
        if (we) mem[paddr] <= wdata;
    end

    if (SYNC) begin : g_sync
        byte_t rdata_q;
        // Registered read, read-before-write on a shared edge.
        always_ff @(posedge clk) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= mem[paddr];
        end
        assign rdata = rdata_q;
    end else begin : g_comb
        assign rdata = mem[paddr];
    end
endmodule

// File: rtl/dmem_lane_array.sv
// Lane-packed physical array: each row holds 2**LANE_W words of WORD_W bits,
// one per logical bank. Stores zero-extend the byte into the lane word.
// The read delivers the whole row (registered or combinational), and the
// byte of the requested lane is sliced out of it.
// Assumes WORD_W >= 8.
module dmem_lane_array
    import dmem_pkg::*;
#(
    parameter int AW     = 4,
    parameter int LANE_W = 1,
    parameter int WORD_W = 9,
    parameter bit SYNC   = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [LANE_W-1:0]                 lane,
    input  logic [AW-1:0]                     addr,
    input  byte_t                             wdata,
    output logic [(1<<LANE_W)*WORD_W-1:0]     row,
    output byte_t                             rdata
);
    localparam int LANES     = 1 << LANE_W;
    localparam int PA_W      = AW + LANE_W;
    localparam int DEPTH     = 1 << PA_W;
    localparam int ROW_W     = LANES * WORD_W;
    localparam int ROW_IDX_W = $clog2(ROW_W);

    logic [WORD_W-1:0]    mem [DEPTH] = '{default: '0};
    logic [ROW_W-1:0]     row_now;
    logic [ROW_IDX_W-1:0] base;

    // Store port: zero-extended byte into the lane word of the row.
    always_ff @(posedge clk) begin
        if (we) mem[{addr, lane}] <= WORD_W'(wdata);
    end

    // Gather all lanes of the addressed row.
    for (genvar l = 0; l < LANES; l++) begin : g_row
        assign row_now[l*WORD_W +: WORD_W] = mem[{addr, LANE_W'(l)}];
    end

    if (SYNC) begin : g_sync
        logic [ROW_W-1:0] row_q;
        // Registered row read, read-before-write on a shared edge.
        always_ff @(posedge clk) begin
            if (!rst_n) row_q <= '0;
            else        row_q <= row_now;
        end
        assign row = row_q;
    end else begin : g_comb
        assign row = row_now;
    end

    // Slice the requested lane's byte out of the row.
    assign base  = ROW_IDX_W'(lane) * ROW_IDX_W'(WORD_W);
    assign rdata = row[base +: DATA_W];
endmodule

// File: rtl/dmem_access_unit.sv
// Banked data memory access unit for an 8-bit stack processor.
// The opcode bank bits pick one of up to four logical memories, and the low
// top-of-stack bits address it. Stores write next-on-stack into writable banks.
// Logical banks live in an offset-packed array (A) or a lane-packed array (B).
// Assumes A_SEL_W and B_LANE_W do not exceed the 2-bit slot field.
module dmem_access_unit
    import dmem_pkg::*;
#(
    parameter int                        A_AW       = 4,
    parameter int                        A_SEL_W    = 1,
    parameter bit                        A_SYNC     = 1'b0,
    parameter bit                        A_INIT_EN  = 1'b1,
    parameter logic [7:0]                A_INIT_MUL = 8'd37,
    parameter logic [7:0]                A_INIT_ADD = 8'd5,
    parameter int                        B_AW       = 4,
    parameter int                        B_LANE_W   = 1,
    parameter int                        B_WORD_W   = 9,
    parameter bit                        B_SYNC     = 1'b1,
    parameter logic [3:0]                BANK_EN    = 4'b1111,
    parameter logic [3:0]                BANK_RAM   = 4'b1101,
    parameter logic [3:0]                BANK_IN_B  = 4'b1100,
    parameter logic [7:0]                BANK_SLOT  = 8'b00_01_01_00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_bank,
    input  logic       wr_cmd,
    input  logic [7:0] tos,
    input  logic [7:0] nos,
    output logic [7:0] rd_data
);
    localparam int B_ROW_W = (1 << B_LANE_W) * B_WORD_W;

    logic              hit_a;
    logic              hit_b;
    logic              we_a;
    logic              we_b;
    logic [SLOT_W-1:0] slot;
    byte_t             a_rdata;
    byte_t             b_rdata;
    logic [B_ROW_W-1:0] b_row;

    dmem_bank_decode #(
        .BANK_EN   (BANK_EN),
        .BANK_RAM  (BANK_RAM),
        .BANK_IN_B (BANK_IN_B),
        .BANK_SLOT (BANK_SLOT)
    ) u_decode (
        .bank   (op_bank),
        .wr_cmd (wr_cmd),
        .hit_a  (hit_a),
        .hit_b  (hit_b),
        .we_a   (we_a),
        .we_b   (we_b),
        .slot   (slot)
    );

    dmem_offset_array #(
        .AW       (A_AW),
        .SEL_W    (A_SEL_W),
        .SYNC     (A_SYNC),
        .INIT_EN  (A_INIT_EN),
        .INIT_MUL (A_INIT_MUL),
        .INIT_ADD (A_INIT_ADD)
    ) u_arr_a (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_a),
        .sel   (slot[A_SEL_W-1:0]),
        .addr  (tos[A_AW-1:0]),
        .wdata (nos),
        .rdata (a_rdata)
    );

    dmem_lane_array #(
        .AW     (B_AW),
        .LANE_W (B_LANE_W),
        .WORD_W (B_WORD_W),
        .SYNC   (B_SYNC)
    ) u_arr_b (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_b),
        .lane  (slot[B_LANE_W-1:0]),
        .addr  (tos[B_AW-1:0]),
        .wdata (nos),
        .row   (b_row),
        .rdata (b_rdata)
    );

    // Result mux: the array of the current bank, or zero for an absent bank.
    always_comb begin
        if (hit_a)      rd_data = a_rdata;
        else if (hit_b) rd_data = b_rdata;
        else            rd_data = '0;
    end
endmodule

// File: rtl/dmem_access_unit_chk.sv
// Property checker for dmem_access_unit, attached by bind. It watches the
// ports together with the decoder's write enables and the lane array's row.
module dmem_access_unit_chk #(
    parameter logic [3:0] BANK_EN  = 4'b1111,
    parameter logic [3:0] BANK_RAM = 4'b1101,
    parameter int         B_WORD_W = 9,
    parameter int         B_LANES  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  op_bank,
    input logic                        wr_cmd,
    input logic [7:0]                  rd_data,
    input logic                        we_a,
    input logic                        we_b,
    input logic [B_LANES*B_WORD_W-1:0] b_row
);
    // R3: no array is written without the store command.
    assert_store_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a || we_b) |-> wr_cmd);

    // R4: a store aimed at a fixed-table bank reaches no array.
    assert_table_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !BANK_RAM[op_bank]) |-> !(we_a || we_b));

    // R1: a store goes to at most one physical array.
    assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_a, we_b}));

    // R9: an absent bank reads zero.
    assert_absent_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !BANK_EN[op_bank] |-> (rd_data == 8'h00));

    // R5: the upper bits of every lane word stay zero.
    if (B_WORD_W > 8) begin : g_ext
        for (genvar l = 0; l < B_LANES; l++) begin : g_lane
            assert_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
                b_row[l*B_WORD_W+8 +: B_WORD_W-8] == '0);
        end
    end
endmodule

bind dmem_access_unit dmem_access_unit_chk #(
    .BANK_EN  (BANK_EN),
    .BANK_RAM (BANK_RAM),
    .B_WORD_W (B_WORD_W),
    .B_LANES  (1 << B_LANE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_bank (op_bank),
    .wr_cmd  (wr_cmd),
    .rd_data (rd_data),
    .we_a    (we_a),
    .we_b    (we_b),
    .b_row   (b_row)
);

// File: tb/dmem_access_unit_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural model of the default configuration is stepped on
// every rising edge and compared 1 ns after each input change.
module dmem_access_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank = 2'd2;
    logic       wr = 1'b0;
    logic [7:0] tos = 8'h00;
    logic [7:0] nos = 8'h00;
    wire  [7:0] rd_main;
    wire  [7:0] rd_alt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dmem_access_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_bank(bank), .wr_cmd(wr),
        .tos(tos), .nos(nos), .rd_data(rd_main)
    );

    dmem_access_unit #(.BANK_EN(4'b0111)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .op_bank(bank), .wr_cmd(wr),
        .tos(tos), .nos(nos), .rd_data(rd_alt)
    );

    // Reference model: offset array (32 bytes), lane array (16 rows x 2 lanes),
    // and the row captured for the registered lane read.
    logic [7:0] m_a [32];
    logic [8:0] m_b [32];
    logic [7:0] r_b [2];

    initial begin
        for (int w = 0; w < 32; w++) m_a[w] = 8'((w * 37 + 5) % 256);
        for (int w = 0; w < 32; w++) m_b[w] = 9'h000;
        r_b[0] = 8'h00;
        r_b[1] = 8'h00;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            r_b[0] <= 8'h00;
            r_b[1] <= 8'h00;
        end else begin
            r_b[0] <= m_b[{tos[3:0], 1'b0}][7:0];
            r_b[1] <= m_b[{tos[3:0], 1'b1}][7:0];
            if (wr) begin
                case (bank)
                    2'd0: m_a[{1'b0, tos[3:0]}] <= nos;
                    2'd2: m_b[{tos[3:0], 1'b1}] <= {1'b0, nos};
                    2'd3: m_b[{tos[3:0], 1'b0}] <= {1'b0, nos};
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] expect_main();
        case (bank)
            2'd0:    return m_a[{1'b0, tos[3:0]}];
            2'd1:    return m_a[{1'b1, tos[3:0]}];
            2'd2:    return r_b[1];
            default: return r_b[0];
        endcase
    endfunction

    task automatic compare(input string req);
        logic [7:0] em;
        logic [7:0] ea;
        em = expect_main();
        ea = (bank == 2'd3) ? 8'h00 : em;
        checks++;
        if (rd_main !== em) begin
            errors++;
            $display("FAIL %s main bank=%0d tos=%h actual=%h expected=%h", req, bank, tos, rd_main, em);
        end
        checks++;
        if (rd_alt !== ea) begin
            errors++;
            $display("FAIL %s alt bank=%0d tos=%h actual=%h expected=%h",
                     (bank == 2'd3) ? "R9" : req, bank, tos, rd_alt, ea);
        end
    endtask

    // One cycle: drive after the falling edge, compare 1 ns later.
    task automatic step(input logic [1:0] b, input logic [7:0] t, input logic [7:0] n,
                        input logic w, input string req);
        @(negedge clk);
        bank = b; tos = t; nos = n; wr = w;
        #1;
        compare(req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lcg;
        // R10: registered lane read cleared during reset; offset array shows image.
        step(2'd2, 8'h03, 8'h00, 1'b0, "R10");
        step(2'd3, 8'h07, 8'h00, 1'b0, "R10");
        step(2'd0, 8'h09, 8'h00, 1'b0, "R10");
        @(negedge clk);
        rst_n = 1'b1;
        step(2'd2, 8'h00, 8'h00, 1'b0, "R10");
        // R4 / R1: fixed table and bank 0 image before any store.
        for (int a = 0; a < 16; a++) begin
            step(2'd1, 8'(a), 8'h00, 1'b0, "R4");
            step(2'd0, 8'(a), 8'h00, 1'b0, "R1");
        end
        // R6: stores to bank 0 leave bank 1 untouched.
        for (int a = 0; a < 16; a++) step(2'd0, 8'(a), 8'(a) ^ 8'hA5, 1'b1, "R6");
        for (int a = 0; a < 16; a++) begin
            step(2'd1, 8'(a), 8'h00, 1'b0, "R6");
            step(2'd0, 8'(a), 8'h00, 1'b0, "R6");
        end
        // R4: store attempts to the fixed table.
        step(2'd1, 8'h04, 8'h77, 1'b1, "R4");
        step(2'd1, 8'h04, 8'h00, 1'b0, "R4");
        step(2'd0, 8'h04, 8'h00, 1'b0, "R4");
        // R3: no store without the command.
        step(2'd0, 8'h02, 8'h11, 1'b0, "R3");
        step(2'd0, 8'h02, 8'h00, 1'b0, "R3");
        step(2'd2, 8'h02, 8'h22, 1'b0, "R3");
        step(2'd2, 8'h02, 8'h00, 1'b0, "R3");
        // R7 / R5: both lanes of each row, then read back.
        for (int a = 0; a < 16; a++) begin
            step(2'd2, 8'(a), 8'(a) + 8'h10, 1'b1, "R7");
            step(2'd3, 8'(a), 8'hF0 - 8'(a), 1'b1, "R5");
        end
        for (int a = 0; a < 16; a++) begin
            step(2'd2, 8'(a), 8'h00, 1'b0, "R7");
            step(2'd3, 8'(a), 8'h00, 1'b0, "R7");
        end
        // R8: read-before-write on the registered lane array, then lane switch.
        step(2'd3, 8'h05, 8'h3C, 1'b1, "R8");
        step(2'd3, 8'h05, 8'h00, 1'b0, "R8");
        step(2'd3, 8'h05, 8'h00, 1'b0, "R8");
        step(2'd2, 8'h05, 8'h00, 1'b0, "R8");
        step(2'd0, 8'h06, 8'h5A, 1'b1, "R8");
        step(2'd0, 8'h06, 8'h00, 1'b0, "R8");
        // R2: upper address bits ignored.
        step(2'd0, 8'hF6, 8'h00, 1'b0, "R2");
        step(2'd0, 8'h36, 8'hC3, 1'b1, "R2");
        step(2'd0, 8'h06, 8'h00, 1'b0, "R2");
        step(2'd2, 8'hE5, 8'h00, 1'b0, "R2");
        step(2'd2, 8'h05, 8'h00, 1'b0, "R2");
        // R9: absent bank in the second instance.
        step(2'd3, 8'h01, 8'h00, 1'b0, "R9");
        step(2'd3, 8'h01, 8'h00, 1'b0, "R9");
        // Mixed traffic from a fixed pseudo-random sequence.
        lcg = 16'h1D2B;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 16'd25173 + 16'd13849;
            step(lcg[15:14], lcg[11:4], lcg[7:0] ^ lcg[15:8], lcg[2], "R1");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule